// File: doc/BRIEF.md
# Load Operand Address Resolver

This block serves the load-to-accumulator step of a small processor. It receives a 4-bit mode code, an address/operand field and a register selector. From these it works out the effective address and reads the operand into an accumulator register. The program counter, the index register and the general register file are not stored here. They arrive as inputs. The program counter input is the already-advanced value, pointing past the two-word instruction. When the mode changes a pointer register, the write-back leaves the block as a one-cycle write strobe.

Memory is reached over a single-port read channel. The block raises a request with an address and holds both steady until the memory answers with a one-cycle ready and the read word. The indirect mode makes two reads: the first fetches the operand's address and the second fetches the operand. The other memory modes make one read. Immediate, register and illegal codes finish without touching memory. A one-cycle done pulse marks each finished operation. A new start is only taken while the block is idle.

Top module: `ea_fetch_unit`

## Requirements
- R1: After reset, acc is 0 and done, err, mem_req, busy and reg_wr_en are all 0. mem_req is never high while busy is low.
- R2: Immediate (code 1) writes addr_field into acc and pulses done one cycle after the start edge, with no memory request.
- R3: Register (code 5) writes the register picked by reg_sel into acc one cycle after start, with no memory request.
- R4: Direct (code 0) makes one read at addr_field. PC-relative (code 3) makes one read at pc_next + addr_field. Indexed (code 4) makes one read at xr + addr_field. All sums wrap modulo 2^W. acc takes the read word, and done pulses one cycle after the ready edge.
- R5: Indirect (code 2) reads at addr_field first. It then reads at the word returned by that first read, and loads the second word into acc.
- R6: Register indirect (code 6) makes one read at the selected register's value and issues no register write.
- R7: Autoincrement (code 7) reads at the register's old value. One cycle after start, it pulses reg_wr_en with that register's number and old value + 1, wrapping.
- R8: Autodecrement (code 8) reads at the register's value - 1. One cycle after start, it writes that same decremented value back to the register, wrapping.
- R9: While ready is low, a pending request keeps mem_req high and mem_addr unchanged.
- R10: Codes 9 to 15 pulse done and err together one cycle after start, leave acc unchanged and issue no request.
- R11: done lasts exactly one cycle per operation. A start raised while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken when idle) |
| mode | input | 4 | Addressing mode code |
| addr_field | input | W | Address or immediate field |
| reg_sel | input | SEL_W | Register selector |
| pc_next | input | W | Program counter already past the instruction |
| xr | input | W | Index register value |
| regs_flat | input | NREG*W | Register file contents, register k at bits [k*W +: W] |
| mem_req | output | 1 | Read request, held until ready |
| mem_addr | output | W | Read address |
| mem_ready | input | 1 | One-cycle read completion |
| mem_rdata | input | W | Read data, valid with mem_ready |
| reg_wr_en | output | 1 | Pointer register write strobe |
| reg_wr_sel | output | SEL_W | Pointer register number |
| reg_wr_data | output | W | Pointer register new value |
| acc | output | W | Accumulator |
| done | output | 1 | Operation complete (one cycle) |
| err | output | 1 | Illegal mode code, valid with done |
| busy | output | 1 | Operation in progress |

## Verification
Results for immediate, register and illegal codes are due at the first falling edge after the start edge. The memory request, its address and any pointer write are also due there. The operand lands in acc, together with done, at the first falling edge after the rising edge that samples ready. For indirect, the second address appears at that same point. The bench drives start and ready on falling edges. It compares every output on each following falling edge against values it works out from the mode rules and its own memory image. While ready is held low for several cycles, it checks on each cycle that the request stays unchanged.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        AM_DIRECT   = 4'd0,
        AM_IMM      = 4'd1,
        AM_INDIRECT = 4'd2,
        AM_PCREL    = 4'd3,
        AM_INDEXED  = 4'd4,
        AM_REG      = 4'd5,
        AM_REGIND   = 4'd6,
        AM_POSTINC  = 4'd7,
        AM_PREDEC   = 4'd8
    } amode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PTR,
        ST_OPND
    } fsm_e;

endpackage

// File: rtl/ea_reg_pick.sv
module ea_reg_pick #(
    parameter int W     = 16,
    parameter int NREG  = 8,
    localparam int SEL_W = $clog2(NREG)
) (
    input  logic [NREG*W-1:0] regs_flat,
    input  logic [SEL_W-1:0]  sel,
    output logic [W-1:0]      val
);

    logic [W-1:0] regs [NREG];

    for (genvar k = 0; k < NREG; k++) begin : g_unpack
        assign regs[k] = regs_flat[k*W +: W];
    end

    assign val = regs[sel];

endmodule

// File: rtl/ea_mode_decode.sv
module ea_mode_decode
    import ea_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [W-1:0]      addr_field,
    input  logic [W-1:0]      pc_next,
    input  logic [W-1:0]      xr,
    input  logic [W-1:0]      reg_val,
    output logic [W-1:0]      first_addr,
    output logic [W-1:0]      local_val,
    output logic [W-1:0]      wb_val,
    output logic              use_mem,
    output logic              two_step,
    output logic              illegal,
    output logic              wb_en
);

    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        first_addr = addr_field;
        local_val  = addr_field;
        wb_val     = reg_val;
        use_mem    = 1'b0;
        two_step   = 1'b0;
        illegal    = 1'b0;
        wb_en      = 1'b0;
        case (mode)
            AM_DIRECT: begin
                use_mem    = 1'b1;
                first_addr = addr_field;
            end
            AM_IMM: begin
                local_val = addr_field;
            end
            AM_INDIRECT: begin
                use_mem    = 1'b1;
                two_step   = 1'b1;
                first_addr = addr_field;
            end
            AM_PCREL: begin
                use_mem    = 1'b1;
                first_addr = pc_next + addr_field;
            end
            AM_INDEXED: begin
                use_mem    = 1'b1;
                first_addr = xr + addr_field;
            end
            AM_REG: begin
                local_val = reg_val;
            end
            AM_REGIND: begin
                use_mem    = 1'b1;
                first_addr = reg_val;
            end
            AM_POSTINC: begin
                use_mem    = 1'b1;
                first_addr = reg_val;
                wb_en      = 1'b1;
                wb_val     = reg_val + ONE;
            end
            AM_PREDEC: begin
                use_mem    = 1'b1;
                first_addr = reg_val - ONE;
                wb_en      = 1'b1;
                wb_val     = reg_val - ONE;
            end
            default: begin
                illegal = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/ea_fetch_unit.sv
module ea_fetch_unit
    import ea_pkg::*;
#(
    parameter int W      = 16,
    parameter int NREG   = 8,
    localparam int SEL_W = $clog2(NREG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [MODE_W-1:0]   mode,
    input  logic [W-1:0]        addr_field,
    input  logic [SEL_W-1:0]    reg_sel,
    input  logic [W-1:0]        pc_next,
    input  logic [W-1:0]        xr,
    input  logic [NREG*W-1:0]   regs_flat,
    output logic                mem_req,
    output logic [W-1:0]        mem_addr,
    input  logic                mem_ready,
    input  logic [W-1:0]        mem_rdata,
    output logic                reg_wr_en,
    output logic [SEL_W-1:0]    reg_wr_sel,
    output logic [W-1:0]        reg_wr_data,
    output logic [W-1:0]        acc,
    output logic                done,
    output logic                err,
    output logic                busy
);

    typedef struct packed {
        fsm_e             st;
        logic [W-1:0]     acc;
        logic             done;
        logic             err;
        logic             req;
        logic [W-1:0]     addr;
        logic             wr_en;
        logic [SEL_W-1:0] wr_sel;
        logic [W-1:0]     wr_data;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [W-1:0] sel_val;
    logic [W-1:0] first_addr, local_val, wb_val;
    logic         use_mem, two_step, illegal, wb_en;

    ea_reg_pick #(.W(W), .NREG(NREG)) u_pick (
        .regs_flat (regs_flat),
        .sel       (reg_sel),
        .val       (sel_val)
    );

    ea_mode_decode #(.W(W)) u_dec (
        .mode       (mode),
        .addr_field (addr_field),
        .pc_next    (pc_next),
        .xr         (xr),
        .reg_val    (sel_val),
        .first_addr (first_addr),
        .local_val  (local_val),
        .wb_val     (wb_val),
        .use_mem    (use_mem),
        .two_step   (two_step),
        .illegal    (illegal),
        .wb_en      (wb_en)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.done  = 1'b0;
        ctl_d.err   = 1'b0;
        ctl_d.wr_en = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (illegal) begin
                        ctl_d.done = 1'b1;
                        ctl_d.err  = 1'b1;
                    end else if (!use_mem) begin
                        ctl_d.acc  = local_val;
                        ctl_d.done = 1'b1;
                    end else begin
                        ctl_d.req     = 1'b1;
                        ctl_d.addr    = first_addr;
                        ctl_d.st      = two_step ? ST_PTR : ST_OPND;
                        ctl_d.wr_en   = wb_en;
                        ctl_d.wr_sel  = reg_sel;
                        ctl_d.wr_data = wb_val;
                    end
                end
            end
            ST_PTR: begin
                if (mem_ready) begin
                    ctl_d.addr = mem_rdata;
                    ctl_d.st   = ST_OPND;
                end
            end
            ST_OPND: begin
                if (mem_ready) begin
                    ctl_d.acc  = mem_rdata;
                    ctl_d.done = 1'b1;
                    ctl_d.req  = 1'b0;
                    ctl_d.st   = ST_IDLE;
                end
            end
            default: begin
                ctl_d.st  = ST_IDLE;
                ctl_d.req = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign mem_req     = ctl_q.req;
    assign mem_addr    = ctl_q.addr;
    assign reg_wr_en   = ctl_q.wr_en;
    assign reg_wr_sel  = ctl_q.wr_sel;
    assign reg_wr_data = ctl_q.wr_data;
    assign acc         = ctl_q.acc;
    assign done        = ctl_q.done;
    assign err         = ctl_q.err;
    assign busy        = (ctl_q.st != ST_IDLE);

    // R1: no request outside an operation
    p_idle_no_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R9: request and address hold until ready
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

    // R10: err only appears with done
    p_err_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    // R10: illegal completion leaves acc untouched
    p_illegal_keeps_acc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy == 1'b0 && start && illegal) |=> $stable(acc));

    // R11: done is a single-cycle pulse
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: pointer write is a single-cycle pulse while a read is pending
    p_wr_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> (mem_req && busy));

endmodule

// File: tb/ea_fetch_unit_tb.sv
module ea_fetch_unit_tb;

    localparam int W = 16;
    localparam int NREG = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [3:0] mode = '0;
    logic [W-1:0] addr_field = '0;
    logic [2:0] reg_sel = '0;
    logic [W-1:0] pc_next = '0;
    logic [W-1:0] xr = '0;
    logic [NREG*W-1:0] regs_flat;
    logic mem_req;
    logic [W-1:0] mem_addr;
    logic mem_ready = 1'b0;
    logic [W-1:0] mem_rdata = '0;
    logic reg_wr_en;
    logic [2:0] reg_wr_sel;
    logic [W-1:0] reg_wr_data;
    logic [W-1:0] acc;
    logic done, err, busy;

    logic [W-1:0] rf [NREG];
    logic [W-1:0] exp_acc = '0;
    int n_tests = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    always_comb begin
        for (int k = 0; k < NREG; k++) regs_flat[k*W +: W] = rf[k];
    end

    ea_fetch_unit #(.W(W), .NREG(NREG)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .addr_field(addr_field), .reg_sel(reg_sel), .pc_next(pc_next),
        .xr(xr), .regs_flat(regs_flat), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
        .reg_wr_data(reg_wr_data), .acc(acc), .done(done), .err(err),
        .busy(busy)
    );

    function automatic logic [W-1:0] memv(input logic [W-1:0] a);
        case (a)
            16'd500: return 16'd800;
            16'd800: return 16'd300;
            16'd702: return 16'd325;
            16'd600: return 16'd900;
            16'd400: return 16'd700;
            16'd399: return 16'd450;
            default: return W'((32'(a) * 3 + 7));
        endcase
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, expv);
        end
    endtask

    task automatic serve(input logic [W-1:0] ea, input int lat, input bit poke,
                         input string rq);
        for (int i = 0; i < lat; i++) begin
            if (poke && i == 0) begin
                start = 1'b1;
                mode = 4'd1;
                addr_field = 16'hFFFF;
            end
            @(negedge clk);
            start = 1'b0;
            chk(mem_req == 1'b1, rq, "req held", int'(mem_req), 1);
            chk(mem_addr == ea, rq, "addr held", int'(mem_addr), int'(ea));
            chk(done == 1'b0, "R11", "no early done", int'(done), 0);
        end
        mem_ready = 1'b1;
        mem_rdata = memv(ea);
        @(negedge clk);
        mem_ready = 1'b0;
        mem_rdata = '0;
    endtask

    task automatic run_op(input logic [3:0] md, input logic [W-1:0] af,
                          input logic [2:0] rs, input int lat, input bit poke,
                          input string rq);
        int kind;
        logic [W-1:0] ea1, ea2, nacc, wbv;
        bit wb;
        kind = 1; ea1 = '0; ea2 = '0; nacc = exp_acc; wb = 1'b0; wbv = '0;
        case (md)
            4'd0: ea1 = af;
            4'd1: begin kind = 0; nacc = af; end
            4'd2: begin kind = 2; ea1 = af; ea2 = memv(af); end
            4'd3: ea1 = pc_next + af;
            4'd4: ea1 = xr + af;
            4'd5: begin kind = 0; nacc = rf[rs]; end
            4'd6: ea1 = rf[rs];
            4'd7: begin ea1 = rf[rs]; wb = 1'b1; wbv = rf[rs] + 16'd1; end
            4'd8: begin ea1 = rf[rs] - 16'd1; wb = 1'b1; wbv = rf[rs] - 16'd1; end
            default: kind = 3;
        endcase
        if (kind == 1) nacc = memv(ea1);
        if (kind == 2) nacc = memv(ea2);

        @(negedge clk);
        start = 1'b1; mode = md; addr_field = af; reg_sel = rs;
        @(negedge clk);
        start = 1'b0;
        chk(reg_wr_en == wb, rq, "pointer write strobe", int'(reg_wr_en), int'(wb));
        if (wb) begin
            chk(reg_wr_sel == rs, rq, "pointer sel", int'(reg_wr_sel), int'(rs));
            chk(reg_wr_data == wbv, rq, "pointer value", int'(reg_wr_data), int'(wbv));
            rf[rs] = reg_wr_data;
        end
        if (kind == 0 || kind == 3) begin
            chk(done == 1'b1, rq, "done", int'(done), 1);
            chk(err == (kind == 3), rq, "err", int'(err), int'(kind == 3));
            chk(acc == nacc, rq, "acc", int'(acc), int'(nacc));
            chk(mem_req == 1'b0, rq, "no request", int'(mem_req), 0);
        end else begin
            chk(done == 1'b0, rq, "done low", int'(done), 0);
            chk(mem_req == 1'b1, rq, "request", int'(mem_req), 1);
            chk(mem_addr == ea1, rq, "first address", int'(mem_addr), int'(ea1));
            serve(ea1, lat, poke, rq);
            if (kind == 2) begin
                chk(mem_req == 1'b1, rq, "second request", int'(mem_req), 1);
                chk(mem_addr == ea2, rq, "second address", int'(mem_addr), int'(ea2));
                chk(done == 1'b0, rq, "done low after first", int'(done), 0);
                serve(ea2, lat, 1'b0, rq);
            end
            chk(done == 1'b1, rq, "done", int'(done), 1);
            chk(err == 1'b0, rq, "err low", int'(err), 0);
            chk(acc == nacc, rq, "acc", int'(acc), int'(nacc));
            chk(mem_req == 1'b0, rq, "request dropped", int'(mem_req), 0);
        end
        exp_acc = nacc;
        @(negedge clk);
        chk(done == 1'b0, "R11", "done one cycle", int'(done), 0);
        chk(acc == exp_acc, "R11", "acc steady", int'(acc), int'(exp_acc));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < NREG; k++) rf[k] = W'(k * 16'h0101);
        rf[1] = 16'd400;
        pc_next = 16'd202;
        xr = 16'd100;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(acc == '0, "R1", "acc", int'(acc), 0);
        chk(done == 1'b0 && err == 1'b0, "R1", "done/err", int'(done), 0);
        chk(mem_req == 1'b0 && busy == 1'b0, "R1", "req/busy", int'(mem_req), 0);
        chk(reg_wr_en == 1'b0, "R1", "wr strobe", int'(reg_wr_en), 0);

        run_op(4'd0, 16'd500, 3'd0, 0, 1'b0, "R4");   // direct -> 800
        run_op(4'd1, 16'd500, 3'd0, 0, 1'b0, "R2");   // immediate -> 500
        run_op(4'd2, 16'd500, 3'd0, 1, 1'b0, "R5");   // indirect -> 300
        run_op(4'd3, 16'd500, 3'd0, 2, 1'b0, "R4");   // relative 702 -> 325
        run_op(4'd4, 16'd500, 3'd0, 0, 1'b0, "R4");   // indexed 600 -> 900
        run_op(4'd5, 16'd500, 3'd1, 0, 1'b0, "R3");   // register -> 400
        run_op(4'd6, 16'd500, 3'd1, 3, 1'b0, "R6");   // reg indirect -> 700
        run_op(4'd8, 16'd500, 3'd1, 0, 1'b0, "R8");   // predec 399 -> 450
        rf[1] = 16'd400;
        run_op(4'd7, 16'd500, 3'd1, 1, 1'b0, "R7");   // postinc 400 -> 700
        run_op(4'd9, 16'd500, 3'd0, 0, 1'b0, "R10");
        run_op(4'd15, 16'd1, 3'd0, 0, 1'b0, "R10");
        run_op(4'd0, 16'd1234, 3'd0, 4, 1'b1, "R9");  // start poke while busy
        rf[3] = 16'hFFFF;
        run_op(4'd7, 16'd0, 3'd3, 0, 1'b0, "R7");     // wrap to 0
        rf[4] = 16'h0000;
        run_op(4'd8, 16'd0, 3'd4, 1, 1'b0, "R8");     // wrap to FFFF
        run_op(4'd3, 16'hFFFF, 3'd0, 0, 1'b0, "R4");  // pc wrap 201
        run_op(4'd2, 16'd77, 3'd0, 2, 1'b1, "R5");
        run_op(4'd5, 16'd0, 3'd6, 0, 1'b0, "R3");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule